// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block keeps the instruction fetch address for a small 8-bit controller whose program memory holds 2K words of 13 bits. Memory is divided into two pages of 1K words each. The 11-bit counter splits into a 10-bit word offset and a page bit in the top position. Each instruction cycle a decoder outside the block presents one command along with its operands: a 10-bit immediate, an 8-bit data byte (the accumulator, or a byte already computed for a register write) and the page-select bit from the status register. The block updates the counter and a circular return stack eight entries deep.

Any command that redirects the counter costs one more cycle. The block raises `stall` for exactly that cycle. During it the counter holds and the block ignores whatever command is presented, so the decoder can discard the word it prefetched. A computed redirect (an add to the counter, or a byte written into it) clears counter bits 8 and 9. It can therefore reach only the first 256 words of the page named by the page-select bit.

Top module: `pgpc_unit`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 0 and `stall` is 0.
- R2: With `cmd` = 0 (step), or the spare code 7, and no stall, `fetch_addr` becomes `fetch_addr`+1 modulo 2048 at the next clock, so 2047 is followed by 0. Neither code raises `stall`.
- R3: `cmd` = 1 (jump) sets `fetch_addr` to {`page_sel`, `imm`}: `page_sel` goes to bit 10 and `imm` to bits 9..0.
- R4: `cmd` = 2 (call) sets the same target as a jump and pushes the old `fetch_addr`+1 onto the return stack.
- R5: `cmd` = 3 (return) loads `fetch_addr` from the most recently pushed stack entry and removes it. Nested calls therefore return in last-in, first-out order.
- R6: `cmd` = 4 (add) sets bits 7..0 of `fetch_addr` to (old bits 7..0 + `data`) mod 256, clears bits 9..8 and loads bit 10 from `page_sel`.
- R7: `cmd` = 5 (move accumulator) and `cmd` = 6 (generic register write) each set `fetch_addr` to {`page_sel`, 2'b00, `data`}.
- R8: After any of codes 1 to 6 is accepted, `stall` is high for exactly the next cycle. During that cycle `fetch_addr` holds and the command presented is ignored.
- R9: The stack holds 8 entries in a circular buffer. A ninth push overwrites the oldest entry. Nine pops after nine pushes return the last eight values pushed, newest first, then the newest value again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one edge per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code: 0 step, 1 jump, 2 call, 3 return, 4 add, 5 move, 6 write, 7 step |
| imm | input | 10 | In-page target for jump and call |
| data | input | 8 | Byte for add, move and write |
| page_sel | input | 1 | Page-select bit from the status register |
| fetch_addr | output | 11 | Current program counter / fetch address |
| stall | output | 1 | High in the extra cycle that follows a redirect |

## Verification
The checker tests on every cycle that a step advances the counter by one, that a jump lands on its page and offset, and that every computed redirect clears bits 9..8 and takes bit 10 from the page select. It also tests that each redirect is followed by exactly one stall cycle in which the counter holds. Stack contents are visible at the ports only through later returns, so only the bench scenarios can show them: the return address after a call, last-in, first-out order for nested calls, and the wrap-around order when nine entries are pushed into eight slots. The same applies to the low-byte carry that the add command discards, and to a command being ignored during a stall.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;

  localparam int PC_W   = 11;  // full counter width (page bit on top)
  localparam int PAGE_W = 10;  // in-page word offset width
  localparam int LOW_W  = 8;   // reach of computed redirects

  typedef enum logic [2:0] {
    CMD_STEP  = 3'd0,
    CMD_JUMP  = 3'd1,
    CMD_CALL  = 3'd2,
    CMD_RET   = 3'd3,
    CMD_ADD   = 3'd4,
    CMD_MOVE  = 3'd5,
    CMD_WRITE = 3'd6,
    CMD_SPARE = 3'd7
  } pgpc_cmd_e;

  // Sequential successor, wrapping within PC_W bits.
  function automatic logic [PC_W-1:0] f_step(input logic [PC_W-1:0] pc);
    return pc + PC_W'(1);
  endfunction

  // Far target for jump and call: page bit plus in-page immediate.
  function automatic logic [PC_W-1:0] f_far(input logic ps,
                                            input logic [PAGE_W-1:0] off);
    return {ps, off};
  endfunction

  // Computed target: page bit, cleared middle bits, new low byte.
  function automatic logic [PC_W-1:0] f_near(input logic ps,
                                             input logic [LOW_W-1:0] low);
    logic [PC_W-1:0] r;
    r = '0;
    r[PC_W-1] = ps;
    r[LOW_W-1:0] = low;
    return r;
  endfunction

  // Low byte sum for the add command; carry out is dropped.
  function automatic logic [LOW_W-1:0] f_add_low(input logic [LOW_W-1:0] pc_low,
                                                 input logic [LOW_W-1:0] a);
    return pc_low + a;
  endfunction

endpackage

// File: rtl/pgpc_stack.sv
module pgpc_stack
  import pgpc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] push_val,
  output logic [PC_W-1:0] top_val
);

  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PC_W-1:0] slot_q [DEPTH];
  logic [SP_W-1:0] sp_q;     // next free slot
  logic [SP_W-1:0] sp_top;   // most recent entry

  assign sp_top  = sp_q - SP_W'(1);
  assign top_val = slot_q[sp_top];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (push) begin
      slot_q[sp_q] <= push_val;
      sp_q         <= sp_q + SP_W'(1);
    end else if (pop) begin
      sp_q <= sp_top;
    end
  end

endmodule

// File: rtl/pgpc_next.sv
module pgpc_next
  import pgpc_pkg::*;
(
  input  logic              stall_q,
  input  logic [PC_W-1:0]   pc_q,
  input  logic [2:0]        cmd,
  input  logic [PAGE_W-1:0] imm,
  input  logic [LOW_W-1:0]  data,
  input  logic              page_sel,
  input  logic [PC_W-1:0]   stack_top,
  output logic [PC_W-1:0]   pc_d,
  output logic [PC_W-1:0]   link_addr,
  output logic              push,
  output logic              pop,
  output logic              redirect
);

  pgpc_cmd_e op;
  assign op        = pgpc_cmd_e'(cmd);
  assign link_addr = f_step(pc_q);

  always_comb begin
    pc_d     = pc_q;
    push     = 1'b0;
    pop      = 1'b0;
    redirect = 1'b0;
    if (!stall_q) begin
      case (op)
        CMD_JUMP: begin
          pc_d     = f_far(page_sel, imm);
          redirect = 1'b1;
        end
        CMD_CALL: begin
          pc_d     = f_far(page_sel, imm);
          push     = 1'b1;
          redirect = 1'b1;
        end
        CMD_RET: begin
          pc_d     = stack_top;
          pop      = 1'b1;
          redirect = 1'b1;
        end
        CMD_ADD: begin
          pc_d     = f_near(page_sel, f_add_low(pc_q[LOW_W-1:0], data));
          redirect = 1'b1;
        end
        CMD_MOVE, CMD_WRITE: begin
          pc_d     = f_near(page_sel, data);
          redirect = 1'b1;
        end
        default: pc_d = link_addr;
      endcase
    end
  end

endmodule

// File: rtl/pgpc_unit.sv
module pgpc_unit
  import pgpc_pkg::*;
#(
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [PAGE_W-1:0] imm,
  input  logic [LOW_W-1:0]  data,
  input  logic              page_sel,
  output logic [PC_W-1:0]   fetch_addr,
  output logic              stall
);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] link_addr;
  logic [PC_W-1:0] stack_top;
  logic            stall_q;
  logic            push;
  logic            pop;
  logic            redirect;  // accepted command changes the PC this edge

  pgpc_next u_next (
    .stall_q   (stall_q),
    .pc_q      (pc_q),
    .cmd       (cmd),
    .imm       (imm),
    .data      (data),
    .page_sel  (page_sel),
    .stack_top (stack_top),
    .pc_d      (pc_d),
    .link_addr (link_addr),
    .push      (push),
    .pop       (pop),
    .redirect  (redirect)
  );

  pgpc_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .push_val (link_addr),
    .top_val  (stack_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      stall_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      stall_q <= redirect;
    end
  end

  assign fetch_addr = pc_q;
  assign stall      = stall_q;

endmodule

// File: rtl/pgpc_checker.sv
module pgpc_checker
  import pgpc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [PAGE_W-1:0] imm,
  input logic              page_sel,
  input logic [PC_W-1:0]   fetch_addr,
  input logic              stall,
  input logic              redirect
);

  logic step_cmd;
  logic near_cmd;
  logic chg_cmd;
  assign step_cmd = (cmd == CMD_STEP) || (cmd == CMD_SPARE);
  assign near_cmd = (cmd == CMD_ADD) || (cmd == CMD_MOVE) || (cmd == CMD_WRITE);
  assign chg_cmd  = !step_cmd;

  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && step_cmd) |=> (fetch_addr == PC_W'($past(fetch_addr) + 1'b1) && !stall)); // R2

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && cmd == CMD_JUMP) |=> (fetch_addr == {$past(page_sel), $past(imm)})); // R3

  AST_NEAR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && near_cmd) |=> (fetch_addr[PAGE_W-1:LOW_W] == '0 && fetch_addr[PC_W-1] == $past(page_sel))); // R6

  AST_REDIRECT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && chg_cmd) |=> stall); // R8

  AST_STALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(fetch_addr)); // R8

  AST_NO_REDIRECT_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !redirect); // R8

endmodule

bind pgpc_unit pgpc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd        (cmd),
  .imm        (imm),
  .page_sel   (page_sel),
  .fetch_addr (fetch_addr),
  .stall      (stall),
  .redirect   (redirect)
);

// File: tb/pgpc_unit_tb_top.sv
`timescale 1ns/100ps
module pgpc_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [9:0]  imm = '0;
  logic [7:0]  data = '0;
  logic        page_sel = 1'b0;
  logic [10:0] fetch_addr;
  logic        stall;

  int n_run = 0;
  int n_fail = 0;
  logic [10:0] exp_pc = '0;

  always #2.5 clk = ~clk;

  pgpc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .imm(imm), .data(data),
    .page_sel(page_sel), .fetch_addr(fetch_addr), .stall(stall)
  );

  task automatic chk(input string tag, input int got, input int want);
    n_run++;
    if (got != want) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, want);
    end
  endtask

  // Starts and ends at a negedge. Steps once.
  task automatic do_step(input string tag);
    cmd = 3'd0;
    @(negedge clk);
    exp_pc = exp_pc + 11'd1;
    chk(tag, fetch_addr, exp_pc);
    chk(tag, stall, 0);
  endtask

  // Issues a redirecting command, checks target and the stall cycle.
  // During the stall cycle 'stall_cmd' is presented and must be ignored.
  task automatic do_redir(input string tag, input logic [2:0] c, input logic [9:0] i,
                          input logic [7:0] d, input logic ps, input logic [10:0] target,
                          input logic [2:0] stall_cmd);
    cmd = c; imm = i; data = d; page_sel = ps;
    @(negedge clk);
    exp_pc = target;
    chk({tag, " target"}, fetch_addr, exp_pc);
    chk("R8 stall high", stall, 1);
    cmd = stall_cmd; imm = ~i; data = ~d; page_sel = ~ps;
    @(negedge clk);
    chk("R8 held in stall", fetch_addr, exp_pc);
    chk("R8 stall one cycle", stall, 0);
    cmd = 3'd0; imm = '0; data = '0; page_sel = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset addr", fetch_addr, 0);
    chk("R1 reset stall", stall, 0);
    rst_n = 1'b1;
    exp_pc = '0;
  endtask

  task automatic t_step();
    for (int k = 0; k < 5; k++) do_step("R2 step");
    cmd = 3'd7;
    @(negedge clk);
    exp_pc = exp_pc + 11'd1;
    chk("R2 spare code steps", fetch_addr, exp_pc);
    chk("R2 spare code no stall", stall, 0);
    do_redir("R3 jump to end", 3'd1, 10'h3FF, 8'h00, 1'b1, 11'h7FF, 3'd0);
    // after the stall cycle, the next edge steps from 0x7FF
    do_step("R2 wrap to 0");
    chk("R2 wrap value", fetch_addr, 0);
  endtask

  task automatic t_jump();
    do_redir("R3 jump page0", 3'd1, 10'h155, 8'h00, 1'b0, 11'h155, 3'd0);
    do_redir("R3 jump page1", 3'd1, 10'h2AA, 8'h00, 1'b1, 11'h6AA, 3'd0);
  endtask

  task automatic t_call_ret();
    logic [10:0] r1, r2;
    do_redir("R3 setup", 3'd1, 10'h040, 8'h00, 1'b0, 11'h040, 3'd0);
    r1 = exp_pc + 11'd1;
    do_redir("R4 call outer", 3'd2, 10'h200, 8'h00, 1'b1, 11'h600, 3'd0);
    do_step("R2 step in sub");
    r2 = exp_pc + 11'd1;
    do_redir("R4 call inner", 3'd2, 10'h123, 8'h00, 1'b0, 11'h123, 3'd0);
    do_redir("R5 ret inner", 3'd3, 10'h000, 8'h00, 1'b0, r2, 3'd0);
    do_redir("R5 ret outer", 3'd3, 10'h000, 8'h00, 1'b0, r1, 3'd0);
  endtask

  task automatic t_add();
    do_redir("R3 setup", 3'd1, 10'h3F0, 8'h00, 1'b0, 11'h3F0, 3'd0);
    // low byte F0 + 20 = 0x110 -> carry dropped, bits 9..8 cleared
    do_redir("R6 add carry dropped", 3'd4, 10'h000, 8'h20, 1'b1, 11'h410, 3'd0);
    do_redir("R3 setup", 3'd1, 10'h105, 8'h00, 1'b1, 11'h505, 3'd0);
    do_redir("R6 add page0", 3'd4, 10'h000, 8'h02, 1'b0, 11'h007, 3'd0);
  endtask

  task automatic t_move();
    do_redir("R3 setup", 3'd1, 10'h3C3, 8'h00, 1'b0, 11'h3C3, 3'd0);
    do_redir("R7 move", 3'd5, 10'h3FF, 8'hAB, 1'b1, 11'h4AB, 3'd0);
    do_redir("R3 setup", 3'd1, 10'h2FF, 8'h00, 1'b1, 11'h6FF, 3'd0);
    do_redir("R7 write", 3'd6, 10'h3FF, 8'h3C, 1'b0, 11'h03C, 3'd0);
  endtask

  task automatic t_stall_ignore();
    // redirect commands presented during the stall cycle have no effect
    do_redir("R8 jump", 3'd1, 10'h0AA, 8'h00, 1'b0, 11'h0AA, 3'd1);
    do_redir("R8 call", 3'd2, 10'h011, 8'h00, 1'b0, 11'h011, 3'd2);
    // stack must hold only the call's link (0x0AB); an ignored call would push another
    do_redir("R8 ret after ignored call", 3'd3, 10'h000, 8'h00, 1'b0, 11'h0AB, 3'd5);
    do_step("R8 step after stall");
  endtask

  task automatic t_stack_wrap();
    logic [10:0] pushed [9];
    for (int k = 0; k < 9; k++) begin
      pushed[k] = exp_pc + 11'd1;
      do_redir("R9 call", 3'd2, 10'((k + 1) * 16), 8'h00, 1'b0, 11'((k + 1) * 16), 3'd0);
    end
    for (int k = 8; k >= 1; k--)
      do_redir("R9 ret order", 3'd3, 10'h000, 8'h00, 1'b0, pushed[k], 3'd0);
    do_redir("R9 ret wraps to newest", 3'd3, 10'h000, 8'h00, 1'b0, pushed[8], 3'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_step();
    t_jump();
    t_call_ret();
    t_add();
    t_move();
    t_stall_ignore();
    t_stack_wrap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule